// File: doc/BRIEF.md
# RS-485 Multidrop Address Filter and Driver Enable

This block sits between a UART's character receiver and its receive FIFO, and beside its transmitter. It controls which received characters are stored and when a half-duplex RS-485 transceiver is driven. In the two multidrop modes, a received 9-bit character with bit 8 set is treated as an address. The address is compared against two programmable station addresses. A match opens the receive path for the data characters that follow, and a miss closes it. Address characters are never stored.

On the transmit side, the block produces the transceiver-enable pin with a selectable active level. In the auto half-duplex mode, the enable follows transmitter activity. Its release is postponed by 0 to 15 bit times after the last stop bit, so that the line stays driven while the final bits travel down a long cable. In the auto transmitter-enable mode, the pin instead follows address matching on the first station address. A separate half-duplex option discards every received character while the transmitter is busy.

Top module: `md_xcvr_ctl`

## Requirements
- R1: After reset, no character is stored and the enable pin sits at its inactive level. In a multidrop mode, reception stays closed until a matching address arrives.
- R2: The multidrop modes use mode codes 3'b011 and 3'b100. In these modes, a character with bit 8 equal to 1 is an address. If its low 8 bits equal either station address, reception opens. The address itself is never stored. Data characters (bit 8 equal to 0) received while reception is open are stored. The `rx_store` pulse appears in the cycle after `rx_valid`.
- R3: In a multidrop mode, an address that equals neither station address closes reception, and the data that follows is not stored.
- R4: With any mode code other than 3'b011 or 3'b100, every accepted character is stored whatever its bit 8, and the enable pin stays inactive.
- R5: In mode 3'b011, the enable goes active at the clock edge that samples `tx_busy` high, before the first bit leaves the transmitter.
- R6: In mode 3'b011 with a delay of 0, the enable goes inactive at the edge that samples `tx_stop_done` high while `tx_busy` is low.
- R7: In mode 3'b011 with a delay N from 1 to 15, the enable goes inactive at the edge that samples the Nth `bit_tick` after `tx_stop_done`.
- R8: If `tx_busy` rises while a delay is still counting, the delay is cancelled and the enable stays active. The next `tx_stop_done` starts a fresh full delay.
- R9: In mode 3'b100, an address matching the first station address makes the enable active. It stays active whatever the transmitter does. Any other address makes it inactive, including one that matches only the second station address, which still opens reception.
- R10: `en_pol` = 1 makes the pin high while active. `en_pol` = 0 makes it low while active.
- R11: With `half_dup` = 1, a character arriving while `tx_busy` is high is not stored, and it has no effect on the address state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Mode code: 3'b011 auto half-duplex, 3'b100 auto transmitter enable, others plain |
| en_pol | input | 1 | Enable active level (1 = high while active) |
| half_dup | input | 1 | Discard received characters while transmitting |
| turn_dly | input | 4 | Release delay in bit times (0 to 15) |
| stn_addr_a | input | 8 | First station address |
| stn_addr_b | input | 8 | Second station address |
| rx_valid | input | 1 | Received-character strobe |
| rx_char | input | 9 | Received character, bit 8 is the address flag |
| tx_busy | input | 1 | Transmitter shifting a character |
| tx_stop_done | input | 1 | Last stop bit of a transmission finished |
| bit_tick | input | 1 | One pulse per bit time |
| rx_store | output | 1 | Write the character to the receive FIFO |
| xcvr_en | output | 1 | Transceiver driver-enable pin |

## Verification
The bench builds the block with its default widths: 9-bit characters, 8-bit addresses and a 4-bit delay field. With these widths, the full delay range is within reach, including the 15-bit-time maximum and the zero-delay immediate release. A cancelled delay is followed by a complete recount. Both station addresses are exercised, as well as an address that matches only the second, and characters with bit 8 set in a non-multidrop mode. A behavioural reference model runs beside the block and checks the store pulse and the pin on every clock, with directed checks at each boundary.

// File: rtl/md_xcvr_pkg.sv
// Shared mode codes for the multidrop transceiver control block.
package md_xcvr_pkg;
    // Mode codes seen on mode_sel; other codes mean plain (no multidrop).
    localparam logic [2:0] MODE_PLAIN = 3'b000;
    localparam logic [2:0] MODE_HDX   = 3'b011;
    localparam logic [2:0] MODE_TXEN  = 3'b100;

    // True when the mode filters on address characters.
    function automatic logic is_multidrop(input logic [2:0] m);
        return (m == MODE_HDX) || (m == MODE_TXEN);
    endfunction
endpackage

// File: rtl/md_addr_filter.sv
// Address filter: decides which received characters are stored.
// Assumes rx_valid is a single-cycle strobe with rx_char valid alongside it.
// The MSB of the character is the address flag in multidrop modes.
module md_addr_filter
    import md_xcvr_pkg::*;
#(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic              half_dup,
    input  logic              tx_busy,
    input  logic [CHAR_W-2:0] stn_addr_a,
    input  logic [CHAR_W-2:0] stn_addr_b,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              rx_store,
    output logic              addr_evt,
    output logic              hit_a
);
    localparam int AW = CHAR_W - 1;

    logic          rcv_on;
    logic          accepted;
    logic          multi;
    logic          hit_b;
    logic [AW-1:0] payload;

    // Qualify the strobe and classify the character.
    always_comb begin
        multi    = is_multidrop(mode_sel);
        accepted = rx_valid && !(half_dup && tx_busy);
        payload  = rx_char[AW-1:0];
        hit_a    = (payload == stn_addr_a);
        hit_b    = (payload == stn_addr_b);
        addr_evt = accepted && multi && rx_char[AW];
    end

    // Track whether this station is currently addressed.
    always_ff @(posedge clk) begin
        if (!rst_n)        rcv_on <= 1'b0;
        else if (!multi)   rcv_on <= 1'b0;
        else if (addr_evt) rcv_on <= hit_a || hit_b;
    end

    // Register the store strobe toward the receive FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_store <= 1'b0;
        else        rx_store <= accepted && (!multi || (!rx_char[AW] && rcv_on));
    end

    // R2
    addr_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_multidrop(mode_sel) && rx_valid && rx_char[AW]) |=> !rx_store);
    // R11
    hd_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && half_dup && tx_busy) |=> !rx_store);
    // R3
    miss_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_evt && !hit_a && !hit_b) |=> !rcv_on);
endmodule

// File: rtl/md_turn_timer.sv
// Turn-around timer: counts bit ticks after a load and flags the last one.
// Assumes load and cancel come from the drive controller; cancel wins.
module md_turn_timer #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             cancel,
    input  logic             bit_tick,
    output logic             expire
);
    logic [DLY_W-1:0] cnt;
    logic             pend;

    // Final tick of a pending count.
    assign expire = pend && bit_tick && (cnt == DLY_W'(1));

    // Count down one per bit tick while pending.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            pend <= (load_val != '0);
            cnt  <= load_val;
        end else if (pend && bit_tick) begin
            if (cnt == DLY_W'(1)) begin
                pend <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt - DLY_W'(1);
            end
        end
    end

    // R7
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (cnt != '0));
    // R8
    cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !pend);
endmodule

// File: rtl/md_drive_ctl.sv
// Drive controller: holds the internal driver-active state for both modes.
// Assumes tx_stop_done marks the end of the final stop bit; tx_busy wins.
module md_drive_ctl
    import md_xcvr_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_sel,
    input  logic [DLY_W-1:0] turn_dly,
    input  logic             tx_busy,
    input  logic             tx_stop_done,
    input  logic             addr_evt,
    input  logic             hit_a,
    input  logic             expire,
    output logic             tmr_load,
    output logic             tmr_cancel,
    output logic             drv
);
    logic hdx;
    logic release_now;

    // Decide timer requests from transmitter events.
    always_comb begin
        hdx         = (mode_sel == MODE_HDX);
        release_now = hdx && !tx_busy && tx_stop_done && drv && (turn_dly == '0);
        tmr_load    = hdx && !tx_busy && tx_stop_done && drv && (turn_dly != '0);
        tmr_cancel  = !hdx || tx_busy || release_now;
    end

    // Update the driver-active state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv <= 1'b0;
        end else if (hdx) begin
            if (tx_busy)          drv <= 1'b1;
            else if (release_now) drv <= 1'b0;
            else if (tmr_load)    drv <= 1'b1;
            else if (expire)      drv <= 1'b0;
        end else if (mode_sel == MODE_TXEN) begin
            if (addr_evt) drv <= hit_a;
        end else begin
            drv <= 1'b0;
        end
    end

    // R5
    busy_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_sel == MODE_HDX) && tx_busy) |=> drv);
    // R9
    addr_a_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_sel == MODE_TXEN) && addr_evt && hit_a) |=> drv);
    // R4
    plain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_multidrop(mode_sel) |=> !drv);
endmodule

// File: rtl/md_xcvr_ctl.sv
// Top: multidrop address filter plus RS-485 driver-enable generation.
// Assumes mode_sel changes only while the line is quiet.
module md_xcvr_ctl #(
    parameter int CHAR_W = 9,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic              en_pol,
    input  logic              half_dup,
    input  logic [DLY_W-1:0]  turn_dly,
    input  logic [CHAR_W-2:0] stn_addr_a,
    input  logic [CHAR_W-2:0] stn_addr_b,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              tx_busy,
    input  logic              tx_stop_done,
    input  logic              bit_tick,
    output logic              rx_store,
    output logic              xcvr_en
);
    logic addr_evt, hit_a, expire, tmr_load, tmr_cancel, drv;

    md_addr_filter #(.CHAR_W(CHAR_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .half_dup(half_dup),
        .tx_busy(tx_busy), .stn_addr_a(stn_addr_a), .stn_addr_b(stn_addr_b),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_store(rx_store),
        .addr_evt(addr_evt), .hit_a(hit_a)
    );

    md_turn_timer #(.DLY_W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(turn_dly),
        .cancel(tmr_cancel), .bit_tick(bit_tick), .expire(expire)
    );

    md_drive_ctl #(.DLY_W(DLY_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .turn_dly(turn_dly),
        .tx_busy(tx_busy), .tx_stop_done(tx_stop_done), .addr_evt(addr_evt),
        .hit_a(hit_a), .expire(expire), .tmr_load(tmr_load),
        .tmr_cancel(tmr_cancel), .drv(drv)
    );

    // Apply the selected active level to the pin.
    assign xcvr_en = en_pol ? drv : !drv;
endmodule

// File: tb/tb_md_xcvr_ctl.sv
module tb_md_xcvr_ctl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic       en_pol = 1'b1;
    logic       half_dup = 1'b0;
    logic [3:0] turn_dly = 4'd0;
    logic [7:0] stn_addr_a = 8'h21;
    logic [7:0] stn_addr_b = 8'h42;
    logic       rx_valid = 1'b0;
    logic [8:0] rx_char = 9'h000;
    logic       tx_busy = 1'b0;
    logic       tx_stop_done = 1'b0;
    logic       bit_tick = 1'b0;
    logic       rx_store, xcvr_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit model_live = 0;

    md_xcvr_ctl dut (.*);

    always #(CLK_P/2) clk = ~clk;

    // Behavioural reference state.
    int m_rcv = 0, m_drv = 0, m_pend = 0, m_cnt = 0;
    bit m_store = 0;

    always @(posedge clk) begin
        bit acc, md, isaddr, ha, hb;
        if (!rst_n) begin
            m_rcv = 0; m_drv = 0; m_pend = 0; m_cnt = 0; m_store = 0;
        end else begin
            acc = rx_valid && !(half_dup && tx_busy);
            md = (mode_sel == 3'b011) || (mode_sel == 3'b100);
            isaddr = acc && md && rx_char[8];
            ha = (rx_char[7:0] == stn_addr_a);
            hb = (rx_char[7:0] == stn_addr_b);
            m_store = acc && (!md || (!rx_char[8] && m_rcv != 0));
            if (!md) m_rcv = 0;
            else if (isaddr) m_rcv = (ha || hb) ? 1 : 0;
            if (mode_sel == 3'b011) begin
                if (tx_busy) begin m_drv = 1; m_pend = 0; end
                else if (tx_stop_done && m_drv != 0) begin
                    if (turn_dly == 0) begin m_drv = 0; m_pend = 0; end
                    else begin m_pend = 1; m_cnt = turn_dly; end
                end else if (m_pend != 0 && bit_tick) begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin m_drv = 0; m_pend = 0; end
                end
            end else if (mode_sel == 3'b100) begin
                m_pend = 0;
                if (isaddr) m_drv = ha ? 1 : 0;
            end else begin
                m_drv = 0; m_pend = 0;
            end
            model_live = 1;
        end
    end

    // Per-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        logic exp_pin;
        if (model_live && !done) begin
            exp_pin = en_pol ? (m_drv != 0) : (m_drv == 0);
            checks++;
            if (rx_store !== m_store) begin
                errors++;
                $display("FAIL R2 model rx_store act=%b exp=%b t=%0t", rx_store, m_store, $time);
            end
            checks++;
            if (xcvr_en !== exp_pin) begin
                errors++;
                $display("FAIL R5 model xcvr_en act=%b exp=%b t=%0t", xcvr_en, exp_pin, $time);
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    // Present one character; afterwards rx_store shows its outcome.
    task automatic send(logic [8:0] c);
        rx_valid = 1'b1; rx_char = c;
        step();
        rx_valid = 1'b0;
    endtask

    task automatic tx_start();
        tx_busy = 1'b1; step(); step();
    endtask

    task automatic tx_end();
        tx_busy = 1'b0; tx_stop_done = 1'b1; step(); tx_stop_done = 1'b0;
    endtask

    task automatic tick();
        step(); bit_tick = 1'b1; step(); bit_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(); step(); step();
        // R1 reset state
        chk("R1 reset rx_store", rx_store, 1'b0);
        chk("R1 reset xcvr_en", xcvr_en, 1'b0);
        rst_n = 1'b1;
        mode_sel = 3'b011;
        step();
        send(9'h055);
        chk("R1 closed after reset", rx_store, 1'b0);
        send(9'h121);
        chk("R2 address a not stored", rx_store, 1'b0);
        send(9'h033);
        chk("R2 data after addr a", rx_store, 1'b1);
        send(9'h142);
        chk("R2 address b not stored", rx_store, 1'b0);
        send(9'h034);
        chk("R2 data after addr b", rx_store, 1'b1);
        send(9'h177);
        chk("R3 miss not stored", rx_store, 1'b0);
        send(9'h035);
        chk("R3 data after miss", rx_store, 1'b0);

        // R5/R6 zero delay
        turn_dly = 4'd0;
        tx_start();
        chk("R5 enable on busy", xcvr_en, 1'b1);
        tx_end();
        chk("R6 immediate release", xcvr_en, 1'b0);

        // R7 delay 3
        turn_dly = 4'd3;
        tx_start();
        tx_end();
        chk("R7 held after stop", xcvr_en, 1'b1);
        tick(); tick();
        chk("R7 held after 2 ticks", xcvr_en, 1'b1);
        tick();
        chk("R7 released at tick 3", xcvr_en, 1'b0);

        // R8 cancel and restart
        tx_start();
        tx_end();
        tick();
        tx_start();
        step(); step();
        chk("R8 held during new tx", xcvr_en, 1'b1);
        tx_end();
        tick(); tick();
        chk("R8 fresh count held", xcvr_en, 1'b1);
        tick();
        chk("R8 fresh count released", xcvr_en, 1'b0);

        // R7 maximum delay 15
        turn_dly = 4'd15;
        tx_start();
        tx_end();
        for (int i = 0; i < 14; i++) tick();
        chk("R7 held at tick 14", xcvr_en, 1'b1);
        tick();
        chk("R7 released at tick 15", xcvr_en, 1'b0);

        // R10 polarity low-active
        turn_dly = 4'd0;
        en_pol = 1'b0;
        step();
        chk("R10 idle high", xcvr_en, 1'b1);
        tx_start();
        chk("R10 active low", xcvr_en, 1'b0);
        tx_end();
        en_pol = 1'b1;

        // R11 half-duplex discard
        half_dup = 1'b1;
        send(9'h121);
        tx_busy = 1'b1;
        step();
        send(9'h036);
        chk("R11 data dropped while tx", rx_store, 1'b0);
        send(9'h177);
        chk("R11 addr dropped while tx", rx_store, 1'b0);
        tx_end();
        send(9'h037);
        chk("R11 addr state untouched", rx_store, 1'b1);
        half_dup = 1'b0;

        // R9 transmitter-enable mode, active low
        mode_sel = 3'b100;
        en_pol = 1'b0;
        step();
        chk("R9 idle inactive", xcvr_en, 1'b1);
        send(9'h121);
        chk("R9 addr a drives", xcvr_en, 1'b0);
        tx_start();
        tx_end();
        step(); step();
        chk("R9 held after tx", xcvr_en, 1'b0);
        send(9'h142);
        chk("R9 addr b releases", xcvr_en, 1'b1);
        send(9'h038);
        chk("R9 addr b opens rx", rx_store, 1'b1);
        send(9'h121);
        send(9'h155);
        chk("R9 miss releases", xcvr_en, 1'b1);
        send(9'h039);
        chk("R3 miss closes rx", rx_store, 1'b0);

        // R4 plain mode
        mode_sel = 3'b000;
        en_pol = 1'b1;
        step();
        send(9'h1AA);
        chk("R4 flagged char stored", rx_store, 1'b1);
        send(9'h011);
        chk("R4 data stored", rx_store, 1'b1);
        tx_start();
        chk("R4 no drive on tx", xcvr_en, 1'b0);
        tx_end();
        step(); step();
        finish_run();
    end
endmodule